// File: doc/BRIEF.md
# Shift-Register Reloadable Clock Divider

This block holds the digital dividers of a frequency synthesizer. Each divider counts with a maximal-length shift register that uses XNOR feedback, not a binary counter. When the register steps into its terminal state, the divider emits a one-cycle tick. On the next enabled cycle it reloads from a programmed code and flips a divided output. To get a divide ratio N, software programs the shift-register state that sits N-1 steps ahead of the terminal state. Two such dividers are built. The reference divider is 6 bits wide and divides by 1 to 64. The feedback divider is 8 bits wide and divides by 2 to 160.

A post-divider chain of two cascaded stages follows the feedback-rate enable. Each stage divides by 1 to 8. Each stage's field holds eight minus its divisor. The chain's tick rate is the input rate divided by the product of the two divisors, with the second divisor kept no larger than the first. All stages advance only on cycles where their clock enable is high. The oscillator and the phase comparison live outside this block.

Top module: `synth_divider_core`

## Requirements
- R1: The reference divider steps its state s as {s[4:0], ~(s[5]^s[4])}, and its terminal state is 0x01. A code that lies N-1 steps before the terminal state gives a tick every N enabled cycles, for N from 2 to 64. For example, code 0x00 divides by 2, 0x20 by 3, 0x10 by 4 and 0x01 by 64.
- R2: The feedback divider steps its state s as {s[6:0], ~(s[7]^s[3]^s[2]^s[1])}, and its terminal state is 0x01. A code N-1 steps before the terminal state gives a tick every N enabled cycles, for N from 2 to 160. For example, 0x00 divides by 2, 0x80 by 3, 0xC0 by 4 and 0xE0 by 5.
- R3: An all-ones code (0x3F on the reference divider) selects divide-by-1. Once this code is reloaded, the tick output equals the enable input on every cycle and the divided output holds its level.
- R4: Each divided output inverts on the clock edge that ends a tick cycle with an ordinary code, and on no other edge.
- R5: A code is sampled only in a tick cycle. A code change made mid-count leaves the current period at the old ratio, and the new ratio starts with the following period.
- R6: State advances only on cycles with the stage's enable high, and a tick is never given in a cycle with that enable low.
- R7: In the post-divider configuration, bits 2:0 hold 8-pd1 and bits 5:3 hold 8-pd2, where a field value of 0 means 8. With pd2 <= pd1, the pixel tick recurs every pd1*pd2 enabled cycles.
- R8: After reset, both divided outputs are low and every stage sits in its terminal state. On the first enabled cycle, each tick output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Clock |
| i_rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i_ref_en | input | 1 | Clock enable at reference input rate |
| i_ref_code | input | 6 | Reload code of the reference divider |
| i_vco_en | input | 1 | Clock enable at oscillator rate |
| i_fb_code | input | 8 | Reload code of the feedback divider |
| i_post_cfg | input | 6 | Post-divider fields: [2:0]=8-pd1, [5:3]=8-pd2 |
| o_ref_tick | output | 1 | Reference divider reload tick |
| o_ref_div | output | 1 | Reference divided output, toggling per reload |
| o_fb_tick | output | 1 | Feedback divider reload tick |
| o_fb_div | output | 1 | Feedback divided output, toggling per reload |
| o_pix_tick | output | 1 | Post-divided tick |

## Verification
A tick is combinational with the enable, so it is due in the same cycle as an enabled terminal state. The divided output flips at the next clock edge, and a new code governs only the period that starts after the next tick. The reset deassertion reaches the stages two clock edges after i_rst_n rises. The bench drives inputs just after each falling edge and samples outputs 1 ns later, which puts each check in the cycle where the result is due. Because the first period after a code change may still use the old code, the bench measures periods only after one tick has passed for a single divider and after two ticks for the cascaded chain.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
  // Reference divider: 6-bit state, XNOR feedback from bits 5 and 4
  localparam int              REF_W    = 6;
  localparam logic [REF_W-1:0] REF_TAPS = 6'b11_0000;
  // Feedback divider: 8-bit state, XNOR feedback from bits 7,3,2,1
  localparam int              FB_W     = 8;
  localparam logic [FB_W-1:0] FB_TAPS  = 8'b1000_1110;
  // Post-divider stage field width and stage count
  localparam int              POST_W   = 3;
  localparam int              POST_N   = 2;
endpackage

// File: rtl/div_rst_sync.sv
module div_rst_sync (
  input  logic i_clk,
  input  logic i_rst_n,
  output logic o_rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge i_clk or negedge i_rst_n) begin
    if (!i_rst_n) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign o_rst_n = sync_q[1];
endmodule

// File: rtl/lfsr_reload_div.sv
module lfsr_reload_div #(
  parameter int           W    = 6,
  parameter logic [W-1:0] TAPS = 6'b11_0000
) (
  input  logic         i_clk,
  input  logic         i_rst_n,
  input  logic         i_en,
  input  logic [W-1:0] i_reload,
  output logic         o_tick,
  output logic         o_div
);
  localparam logic [W-1:0] TERM = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] LOCK = {W{1'b1}};

  logic [W-1:0] lfsr_q, lfsr_d, step_v;
  logic         term_q, term_d;
  logic         div_q, div_d;
  logic         rld_go, is_lock;

  // XNOR feedback: the all-ones state maps onto itself and is never reached
  assign step_v  = {lfsr_q[W-2:0], ~(^(lfsr_q & TAPS))};
  assign is_lock = (i_reload == LOCK);
  assign rld_go  = i_en & term_q;

  always_comb begin
    lfsr_d = lfsr_q;
    term_d = term_q;
    div_d  = div_q;
    if (rld_go) begin
      // reload cycle: code sampled here only; all-ones keeps the stage terminal
      lfsr_d = i_reload;
      term_d = is_lock;
      div_d  = is_lock ? div_q : ~div_q;
    end else begin
      lfsr_d = step_v;
      term_d = (step_v == TERM);
    end
  end

  always_ff @(posedge i_clk or negedge i_rst_n) begin
    if (!i_rst_n) begin
      lfsr_q <= TERM;
      term_q <= 1'b1;
      div_q  <= 1'b0;
    end else if (i_en) begin
      lfsr_q <= lfsr_d;
      term_q <= term_d;
      div_q  <= div_d;
    end
  end

  assign o_tick = rld_go;
  assign o_div  = div_q;

  // R1/R2: a counting stage never sits in the lockup state
  p_no_lockup_r1: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    !term_q |-> (lfsr_q != LOCK));
  // R4: divided output moves only after a tick cycle
  p_div_only_on_tick_r4: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    !(i_en && term_q) |=> $stable(o_div));
  // R5: an ordinary code is taken into the state at the reload edge
  p_code_loaded_r5: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    (i_en && term_q && (i_reload != LOCK)) |=> (!term_q && lfsr_q == $past(i_reload)));
  // R3: divide-by-1 keeps the stage in its terminal state
  p_bypass_stays_r3: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    (i_en && term_q && (i_reload == LOCK)) |=> term_q);
  // R6: no progress without enable
  p_idle_hold_r6: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    !i_en |=> ($stable(lfsr_q) && $stable(term_q)));
endmodule

// File: rtl/post_div_stage.sv
module post_div_stage #(
  parameter int W = 3
) (
  input  logic         i_clk,
  input  logic         i_rst_n,
  input  logic         i_en,
  input  logic [W-1:0] i_code,
  output logic         o_tick
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  // counts from the code up to all-ones: period = 2**W - code
  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = wrap ? i_code : cnt_q + 1'b1;
  end

  always_ff @(posedge i_clk or negedge i_rst_n) begin
    if (!i_rst_n)  cnt_q <= LAST;
    else if (i_en) cnt_q <= cnt_d;
  end

  assign o_tick = i_en & wrap;

  // R6: the stage count holds while its enable is low
  p_post_hold_r6: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    !i_en |=> $stable(cnt_q));
  // R7: after a wrap the count equals the sampled field
  p_post_reload_r7: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    (i_en && wrap) |=> (cnt_q == $past(i_code)));
endmodule

// File: rtl/synth_divider_core.sv
module synth_divider_core
  import synth_div_pkg::*;
#(
  parameter int                RW     = REF_W,
  parameter logic [RW-1:0]     RTAPS  = REF_TAPS,
  parameter int                FW     = FB_W,
  parameter logic [FW-1:0]     FTAPS  = FB_TAPS,
  parameter int                PW     = POST_W,
  parameter int                PSTG   = POST_N
) (
  input  logic             i_clk,
  input  logic             i_rst_n,
  input  logic             i_ref_en,
  input  logic [RW-1:0]    i_ref_code,
  input  logic             i_vco_en,
  input  logic [FW-1:0]    i_fb_code,
  input  logic [PW*PSTG-1:0] i_post_cfg,
  output logic             o_ref_tick,
  output logic             o_ref_div,
  output logic             o_fb_tick,
  output logic             o_fb_div,
  output logic             o_pix_tick
);
  logic           rst_n;
  logic [PSTG:0]  post_en;

  div_rst_sync u_rst_sync (
    .i_clk   (i_clk),
    .i_rst_n (i_rst_n),
    .o_rst_n (rst_n)
  );

  lfsr_reload_div #(.W(RW), .TAPS(RTAPS)) u_ref_div (
    .i_clk    (i_clk),
    .i_rst_n  (rst_n),
    .i_en     (i_ref_en),
    .i_reload (i_ref_code),
    .o_tick   (o_ref_tick),
    .o_div    (o_ref_div)
  );

  lfsr_reload_div #(.W(FW), .TAPS(FTAPS)) u_fb_div (
    .i_clk    (i_clk),
    .i_rst_n  (rst_n),
    .i_en     (i_vco_en),
    .i_reload (i_fb_code),
    .o_tick   (o_fb_tick),
    .o_div    (o_fb_div)
  );

  // cascaded post-divider: stage g is enabled by the tick of stage g-1
  assign post_en[0] = i_vco_en;

  for (genvar g = 0; g < PSTG; g++) begin : g_post
    post_div_stage #(.W(PW)) u_stage (
      .i_clk   (i_clk),
      .i_rst_n (rst_n),
      .i_en    (post_en[g]),
      .i_code  (i_post_cfg[g*PW +: PW]),
      .o_tick  (post_en[g+1])
    );
  end

  assign o_pix_tick = post_en[PSTG];

  // R7: the chain tick never fires without the oscillator-rate enable
  p_pix_needs_en_r7: assert property (@(posedge i_clk) disable iff (!rst_n)
    o_pix_tick |-> i_vco_en);
endmodule

// File: tb/synth_divider_core_bench.sv
`timescale 1ns/1ps
module synth_divider_core_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_en, vco_en;
  logic [5:0] ref_code;
  logic [7:0] fb_code;
  logic [5:0] post_cfg;
  logic       ref_tick, ref_div, fb_tick, fb_div, pix_tick;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  synth_divider_core u_synth_divider_core (
    .i_clk      (clk),
    .i_rst_n    (rst_n),
    .i_ref_en   (ref_en),
    .i_ref_code (ref_code),
    .i_vco_en   (vco_en),
    .i_fb_code  (fb_code),
    .i_post_cfg (post_cfg),
    .o_ref_tick (ref_tick),
    .o_ref_div  (ref_div),
    .o_fb_tick  (fb_tick),
    .o_fb_div   (fb_div),
    .o_pix_tick (pix_tick)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // state step from R1 (w=6) and R2 (w=8)
  function automatic logic [7:0] step_of(input int w, input logic [7:0] s);
    if (w == 6) return {2'b00, s[4:0], ~(s[5] ^ s[4])};
    return {s[6:0], ~(s[7] ^ s[3] ^ s[2] ^ s[1])};
  endfunction

  // code that lies n-1 steps before the terminal state 0x01
  function automatic logic [7:0] code_for(input int w, input int n);
    int len = (1 << w) - 1;
    logic [7:0] s = 8'h01;
    if (n == 1) return (w == 6) ? 8'h3f : 8'hff;
    for (int k = 0; k < len - (n - 1); k++) s = step_of(w, s);
    return s;
  endfunction

  function automatic logic [5:0] post_of(input int pd1, input int pd2);
    logic [2:0] c1 = 3'(8 - pd1);
    logic [2:0] c2 = 3'(8 - pd2);
    return {c2, c1};
  endfunction

  // sel 0: reference, 1: feedback, 2: post chain. Counts enabled cycles
  // between ticks after discarding 'skip' ticks; 'start' preloads the count.
  task automatic measure(input int sel, input int skip, input int start,
                         input string req, output int per);
    int cnt = start;
    int seen = 0;
    bit en, tk;
    per = -1;
    for (int it = 0; it < 4000; it++) begin
      @(negedge clk);
      en = ($urandom % 4) != 0;
      if (sel == 0) ref_en = en; else vco_en = en;
      #1;
      tk = (sel == 0) ? ref_tick : (sel == 1) ? fb_tick : pix_tick;
      if (tk && !en) check(1'b0, "R6", "tick without enable", 1, 0);
      if (en) cnt++;
      if (tk) begin
        if (seen < skip) begin seen++; cnt = 0; end
        else begin per = cnt; break; end
      end
    end
  endtask

  // after a tick sampled this cycle, divided output must flip (R4)
  task automatic check_toggle(input int sel, input string req);
    bit d0;
    d0 = (sel == 0) ? ref_div : fb_div;
    @(negedge clk);
    if (sel == 0) ref_en = 1'b0; else vco_en = 1'b0;
    #1;
    check(((sel == 0) ? ref_div : fb_div) != d0, req, "divided output toggle",
          (sel == 0) ? int'(ref_div) : int'(fb_div), int'(~d0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int p;
    void'($urandom(32'h1234_5eed));
    rst_n    = 1'b0;
    ref_en   = 1'b0;
    vco_en   = 1'b0;
    ref_code = 6'h00;
    fb_code  = 8'h00;
    post_cfg = 6'h00;
    repeat (3) @(negedge clk);
    #1;
    check(ref_div == 1'b0, "R8", "ref div in reset", int'(ref_div), 0);
    check(fb_div == 1'b0, "R8", "fb div in reset", int'(fb_div), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(ref_tick == 1'b0, "R6", "no ref tick while disabled", int'(ref_tick), 0);
    check(ref_div == 1'b0 && fb_div == 1'b0, "R8", "outputs low after reset",
          int'(ref_div) + int'(fb_div), 0);
    @(negedge clk);
    ref_en = 1'b1;
    vco_en = 1'b1;
    #1;
    check(ref_tick, "R8", "first enabled ref tick", int'(ref_tick), 1);
    check(fb_tick, "R8", "first enabled fb tick", int'(fb_tick), 1);
    check(pix_tick, "R8", "first enabled pix tick", int'(pix_tick), 1);

    // R1: stated codes for the reference divider
    ref_code = 6'h00; measure(0, 1, 0, "R1", p); check(p == 2,  "R1", "code 0x00", p, 2);
    ref_code = 6'h20; measure(0, 1, 0, "R1", p); check(p == 3,  "R1", "code 0x20", p, 3);
    ref_code = 6'h10; measure(0, 1, 0, "R1", p); check(p == 4,  "R1", "code 0x10", p, 4);
    ref_code = 6'h01; measure(0, 1, 0, "R1", p); check(p == 64, "R1", "code 0x01", p, 64);
    // R2: stated codes for the feedback divider
    fb_code = 8'h00; measure(1, 1, 0, "R2", p); check(p == 2, "R2", "code 0x00", p, 2);
    fb_code = 8'h80; measure(1, 1, 0, "R2", p); check(p == 3, "R2", "code 0x80", p, 3);
    fb_code = 8'hC0; measure(1, 1, 0, "R2", p); check(p == 4, "R2", "code 0xC0", p, 4);
    fb_code = 8'hE0; measure(1, 1, 0, "R2", p); check(p == 5, "R2", "code 0xE0", p, 5);

    // R1 sweep with toggle checks (R4)
    for (int n = 2; n <= 64; n++) begin
      ref_code = code_for(6, n)[5:0];
      measure(0, 1, 0, "R1", p);
      check(p == n, "R1", $sformatf("ref divide %0d", n), p, n);
      check_toggle(0, "R4");
    end
    // R2 sweep
    for (int n = 2; n <= 160; n++) begin
      fb_code = code_for(8, n);
      measure(1, 1, 0, "R2", p);
      check(p == n, "R2", $sformatf("fb divide %0d", n), p, n);
      if (n % 16 == 0) check_toggle(1, "R4");
    end

    // R5: mid-count change on the reference divider
    ref_code = code_for(6, 20)[5:0];
    measure(0, 1, 0, "R5", p);
    @(negedge clk); ref_en = 1'b1; #1;
    @(negedge clk); ref_en = 1'b1; #1;
    ref_code = code_for(6, 5)[5:0];
    measure(0, 0, 2, "R5", p);
    check(p == 20, "R5", "period after mid-count change", p, 20);
    measure(0, 0, 0, "R5", p);
    check(p == 5, "R5", "following period uses new code", p, 5);
    // R5 on the feedback divider
    fb_code = code_for(8, 100);
    measure(1, 1, 0, "R5", p);
    @(negedge clk); vco_en = 1'b1; #1;
    fb_code = code_for(8, 7);
    measure(1, 0, 1, "R5", p);
    check(p == 100, "R5", "fb period after mid-count change", p, 100);
    measure(1, 0, 0, "R5", p);
    check(p == 7, "R5", "fb following period", p, 7);

    // R3: divide-by-1 on the reference divider
    ref_code = 6'h3f;
    measure(0, 0, 0, "R3", p);
    begin
      bit d0 = ref_div;
      bit ok = 1'b1;
      for (int k = 0; k < 2; k++) begin @(negedge clk); ref_en = 1'b1; end
      d0 = ref_div;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        ref_en = ($urandom % 2) != 0;
        #1;
        if (ref_tick != ref_en) ok = 1'b0;
        if (ref_div != d0) ok = 1'b0;
      end
      check(ok, "R3", "tick mirrors enable, output held", int'(ok), 1);
    end
    ref_code = code_for(6, 9)[5:0];
    measure(0, 1, 0, "R3", p);
    check(p == 9, "R3", "leaving divide-by-1", p, 9);

    // R7: post-divider for every legal pair
    for (int a = 1; a <= 8; a++) begin
      for (int b = 1; b <= a; b++) begin
        post_cfg = post_of(a, b);
        measure(2, 2, 0, "R7", p);
        check(p == a * b, "R7", $sformatf("post %0dx%0d", a, b), p, a * b);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule